// File: doc/BRIEF.md
# USB Receive Packet Error Classifier

This block sits behind the serial engine of a USB device endpoint on the receive side. It writes each received byte into the endpoint's receive FIFO. At end of packet it decides whether the packet was good, overran the FIFO, had no bit count that divides by eight, failed its CRC, or arrived when no receive buffer was free.

The verdict appears one cycle after the end-of-packet strobe, as a single registered pulse. For a packet that had a buffer, that pulse closes the buffer, carries the per-error status bits and raises the receive event. For a packet that had no buffer, the pulse raises the busy event instead. In the same cycle a handshake select tells the transmit side to send ACK, NAK or nothing.

When a byte arrives while the FIFO is full, it replaces the byte written just before it rather than being dropped. Isochronous endpoints report errors but never request a handshake. Deserialisation and CRC computation are done elsewhere.

Top module: `usb_rx_err_classify`

## Requirements
- R1: A byte strobe (`byte_vld`=1) on a packet that has a buffer, while `fifo_full`=0, asserts `fifo_wr` in the same cycle with `fifo_ovw`=0 and `fifo_data` equal to `byte_in`.
- R2: A byte strobe on a packet that has a buffer, while `fifo_full`=1, asserts `fifo_wr` and `fifo_ovw` together in the same cycle, so the new byte replaces the previous one.
- R3: One cycle after `eop`, `hs_vld` pulses for exactly one cycle. For a packet that has a buffer, `buf_close` and `ev_rxb` pulse in that same cycle.
- R4: A clean packet closes with `st_ov`, `st_no` and `st_crc` all 0. On a non-isochronous endpoint it selects ACK (`hs_sel`=2'b01).
- R5: A packet that overran the FIFO closes with `st_ov`=1. On a non-isochronous endpoint it selects NAK (`hs_sel`=2'b10) when neither a CRC error nor a non-octet error occurred.
- R6: A packet whose `bit_resid` at `eop` is nonzero closes with `st_no`=1 and selects no handshake (`hs_sel`=2'b00).
- R7: A packet whose `crc_ok` at `eop` is 0 closes with `st_crc`=1 and selects no handshake, so the host times out.
- R8: The status bits are independent of each other: overrun, non-octet and CRC errors may all be flagged in the same close.
- R9: Whether a packet has a buffer is decided by `buf_avail`. It is sampled at the packet's first byte, or at `eop` for a packet with no bytes. A packet without a buffer writes no bytes, produces no `buf_close` and no `ev_rxb`, and pulses `ev_bsy`. On a non-isochronous endpoint it selects NAK.
- R10: When `iso_mode`=1 at `eop`, the status bits are reported as usual but `hs_sel` is 2'b00 for every outcome.
- R11: After reset all registered outputs are 0.
- R12: Changes of `buf_avail` after a packet's first byte have no effect on that packet's writes or on its verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iso_mode | input | 1 | Endpoint is isochronous |
| buf_avail | input | 1 | A receive buffer is free |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | DATA_W | Received byte |
| fifo_full | input | 1 | Receive FIFO is full |
| eop | input | 1 | End-of-packet strobe |
| bit_resid | input | RESID_W | Bit count of the packet modulo eight |
| crc_ok | input | 1 | CRC check passed (valid with eop) |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_ovw | output | 1 | Write replaces the last written byte |
| fifo_data | output | DATA_W | FIFO write data |
| buf_close | output | 1 | Close the receive buffer |
| st_ov | output | 1 | Status: FIFO overrun |
| st_no | output | 1 | Status: not octet aligned |
| st_crc | output | 1 | Status: CRC failure |
| ev_rxb | output | 1 | Receive buffer event |
| ev_bsy | output | 1 | Busy event (packet discarded) |
| hs_vld | output | 1 | Handshake select valid |
| hs_sel | output | 2 | 00 none, 01 ACK, 10 NAK |

## Verification
The assertions assume that the serial engine never raises `byte_vld` and `eop` in the same cycle, and that `crc_ok` and `bit_resid` are meaningful only alongside `eop`. The bench drives every byte and every end-of-packet on separate cycles, so stimulus never breaks that rule. Random packets vary byte count, per-byte FIFO fullness, buffer availability at and after the first byte, residue, CRC result and isochronous mode. Directed packets cover the empty packet, a packet with every error at once and a busy isochronous packet.

// File: rtl/usb_rx_err_classify.sv
module usb_rx_err_classify #(
  parameter int DATA_W  = 8,
  parameter int RESID_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iso_mode,
  input  logic               buf_avail,
  input  logic               byte_vld,
  input  logic [DATA_W-1:0]  byte_in,
  input  logic               fifo_full,
  input  logic               eop,
  input  logic [RESID_W-1:0] bit_resid,
  input  logic               crc_ok,
  output logic               fifo_wr,
  output logic               fifo_ovw,
  output logic [DATA_W-1:0]  fifo_data,
  output logic               buf_close,
  output logic               st_ov,
  output logic               st_no,
  output logic               st_crc,
  output logic               ev_rxb,
  output logic               ev_bsy,
  output logic               hs_vld,
  output logic [1:0]         hs_sel
);

  localparam logic [1:0] HS_NONE = 2'b00;
  localparam logic [1:0] HS_ACK  = 2'b01;
  localparam logic [1:0] HS_NAK  = 2'b10;

  logic in_pkt, acc_q, ov_q;
  logic acc_now, bad_no, bad_crc;

  assign acc_now   = in_pkt ? acc_q : buf_avail;
  assign fifo_wr   = byte_vld & acc_now;
  assign fifo_ovw  = fifo_wr & fifo_full;
  assign fifo_data = byte_in;
  assign bad_no    = |bit_resid;
  assign bad_crc   = ~crc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      acc_q  <= 1'b0;
      ov_q   <= 1'b0;
    end else if (eop) begin
      in_pkt <= 1'b0;
      ov_q   <= 1'b0;
    end else if (byte_vld) begin
      in_pkt <= 1'b1;
      if (!in_pkt) acc_q <= buf_avail;
      if (fifo_ovw) ov_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_close <= 1'b0;
      st_ov     <= 1'b0;
      st_no     <= 1'b0;
      st_crc    <= 1'b0;
      ev_rxb    <= 1'b0;
      ev_bsy    <= 1'b0;
      hs_vld    <= 1'b0;
      hs_sel    <= HS_NONE;
    end else begin
      buf_close <= 1'b0;
      st_ov     <= 1'b0;
      st_no     <= 1'b0;
      st_crc    <= 1'b0;
      ev_rxb    <= 1'b0;
      ev_bsy    <= 1'b0;
      hs_vld    <= eop;
      hs_sel    <= HS_NONE;
      if (eop) begin
        if (acc_now) begin
          buf_close <= 1'b1;
          ev_rxb    <= 1'b1;
          st_ov     <= ov_q;
          st_no     <= bad_no;
          st_crc    <= bad_crc;
          if (!iso_mode && !bad_no && !bad_crc)
            hs_sel <= ov_q ? HS_NAK : HS_ACK;
        end else begin
          ev_bsy <= 1'b1;
          if (!iso_mode) hs_sel <= HS_NAK;
        end
      end
    end
  end

  assert_in_sep: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && eop));

  // R1, R2: a write only ever follows a byte strobe
  assert_wr_needs_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> byte_vld);

  assert_ovw_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovw |-> (fifo_wr && fifo_full));

  assert_hs_after_eop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> hs_vld);

  assert_hs_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_vld |=> !hs_vld);

  assert_close_xor_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_vld |-> (buf_close != ev_bsy));

  assert_status_only_on_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ov || st_no || st_crc) |-> buf_close);

  assert_iso_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && iso_mode) |=> (hs_sel == HS_NONE));

  assert_crc_no_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_crc |-> (hs_sel == HS_NONE));

  assert_hs_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_sel != 2'b11);

endmodule

// File: tb/tb_usb_rx_err_classify.sv
module tb_usb_rx_err_classify;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iso_mode = 1'b0, buf_avail = 1'b0, byte_vld = 1'b0, fifo_full = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       eop = 1'b0, crc_ok = 1'b1;
  logic [2:0] bit_resid = 3'd0;
  logic       fifo_wr, fifo_ovw, buf_close, st_ov, st_no, st_crc, ev_rxb, ev_bsy, hs_vld;
  logic [7:0] fifo_data;
  logic [1:0] hs_sel;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  usb_rx_err_classify dut (
    .clk(clk), .rst_n(rst_n), .iso_mode(iso_mode), .buf_avail(buf_avail),
    .byte_vld(byte_vld), .byte_in(byte_in), .fifo_full(fifo_full), .eop(eop),
    .bit_resid(bit_resid), .crc_ok(crc_ok), .fifo_wr(fifo_wr), .fifo_ovw(fifo_ovw),
    .fifo_data(fifo_data), .buf_close(buf_close), .st_ov(st_ov), .st_no(st_no),
    .st_crc(st_crc), .ev_rxb(ev_rxb), .ev_bsy(ev_bsy), .hs_vld(hs_vld), .hs_sel(hs_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hs(input logic acc, input logic iso, input logic ov,
                                        input logic no, input logic crc_bad);
    if (iso) return 2'b00;
    if (!acc) return 2'b10;
    if (no || crc_bad) return 2'b00;
    return ov ? 2'b10 : 2'b01;
  endfunction

  task automatic send_pkt(input int nbytes, input logic avail0, input logic avail_late,
                          input logic [7:0] full_mask, input logic [2:0] resid,
                          input logic crc, input logic iso);
    logic acc, ov;
    acc = avail0;
    ov = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      buf_avail = (i == 0) ? avail0 : avail_late;
      byte_vld = 1'b1;
      byte_in = 8'($urandom);
      fifo_full = full_mask[i];
      #1;
      chk("R1/R9/R12 fifo_wr", 32'(fifo_wr), 32'(acc));
      chk("R2 fifo_ovw", 32'(fifo_ovw), 32'(acc & full_mask[i]));
      if (acc) chk("R1 fifo_data", 32'(fifo_data), 32'(byte_in));
      if (acc && full_mask[i]) ov = 1'b1;
    end
    @(negedge clk);
    byte_vld = 1'b0;
    fifo_full = 1'b0;
    if (nbytes == 0) buf_avail = avail0;
    else buf_avail = avail_late;
    eop = 1'b1;
    bit_resid = resid;
    crc_ok = crc;
    iso_mode = iso;
    @(negedge clk);
    eop = 1'b0;
    bit_resid = 3'($urandom);
    crc_ok = 1'($urandom);
    iso_mode = 1'($urandom);
    #1;
    chk("R3 hs_vld", 32'(hs_vld), 32'd1);
    chk("R3/R9 buf_close", 32'(buf_close), 32'(acc));
    chk("R3 ev_rxb", 32'(ev_rxb), 32'(acc));
    chk("R9 ev_bsy", 32'(ev_bsy), 32'(!acc));
    chk("R5/R8 st_ov", 32'(st_ov), 32'(acc & ov));
    chk("R6/R8 st_no", 32'(st_no), 32'(acc & (resid != 0)));
    chk("R7/R8 st_crc", 32'(st_crc), 32'(acc & !crc));
    chk("R4/R5/R6/R7/R9/R10 hs_sel", 32'(hs_sel), 32'(exp_hs(acc, iso, ov, resid != 0, !crc)));
    @(negedge clk);
    #1;
    chk("R3 one-cycle pulse", 32'({hs_vld, buf_close, ev_rxb, ev_bsy}), 32'd0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset outputs", 32'({buf_close, st_ov, st_no, st_crc, ev_rxb, ev_bsy, hs_vld, hs_sel}), 32'd0);
    rst_n = 1'b1;
    send_pkt(3, 1'b1, 1'b1, 8'h00, 3'd0, 1'b1, 1'b0);
    send_pkt(4, 1'b1, 1'b1, 8'h04, 3'd0, 1'b1, 1'b0);
    send_pkt(2, 1'b1, 1'b0, 8'h00, 3'd5, 1'b1, 1'b0);
    send_pkt(2, 1'b1, 1'b1, 8'h00, 3'd0, 1'b0, 1'b0);
    send_pkt(3, 1'b1, 1'b1, 8'h06, 3'd3, 1'b0, 1'b0);
    send_pkt(3, 1'b0, 1'b1, 8'h00, 3'd0, 1'b1, 1'b0);
    send_pkt(0, 1'b0, 1'b0, 8'h00, 3'd0, 1'b1, 1'b0);
    send_pkt(0, 1'b1, 1'b1, 8'h00, 3'd0, 1'b1, 1'b0);
    send_pkt(2, 1'b1, 1'b1, 8'h00, 3'd0, 1'b0, 1'b1);
    send_pkt(2, 1'b0, 1'b1, 8'h00, 3'd0, 1'b1, 1'b1);
    send_pkt(2, 1'b1, 1'b1, 8'h00, 3'd0, 1'b1, 1'b1);
    for (int k = 0; k < 300; k++) begin
      send_pkt(int'($urandom_range(0, 6)), 1'($urandom_range(0, 3) != 0), 1'($urandom),
               8'($urandom) & 8'($urandom), ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0,
               $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule